// File: doc/BRIEF.md
# Parity Error Concealment Unit

This block sits in the audio sample path directly behind a digital audio interface receiver. Each incoming sample carries a channel index, a parity error flag and a flag marking the stream as non-PCM. When concealment applies to a sample, a short run of parity-errored samples is hidden by repeating the last clean sample of the same channel. If the run of errors goes on, the output is forced to zero.

A two-bit mode field chooses how concealment applies. It can be off. It can cover PCM data only. It can cover PCM and non-PCM data alike. The remaining code is reserved and behaves like off. A separate enable input, set by default in the system, can turn the processing off completely.

The block also guards the status side-channels: validity, user, channel status and the non-PCM format flag. Their held copies refresh only after the stream has been parity-clean for more than a full block of frames. A frame is one sample on each channel, and it ends with the highest channel index.

Top module: `parity_conceal`

## Requirements
- R1: During and after reset, out_valid, out_chan, out_sample, stat_open and all held status outputs are 0.
- R2: With cfg_mode = 00, every valid sample appears on out_sample one clock later unchanged, even when in_perr is 1.
- R3: The reserved code cfg_mode = 11 behaves exactly like cfg_mode = 00.
- R4: With cfg_mode = 01, concealment applies only when in_nonpcm = 0. Errored samples with in_nonpcm = 1 pass unchanged.
- R5: With cfg_mode = 10, concealment applies whatever the value of in_nonpcm.
- R6: When concealment applies, errors 1 to 8 of a run of consecutive errored samples each output the last clean sample of the channel named by in_chan. The last-clean store is kept separately for each channel.
- R7: From the ninth consecutive errored sample onward, the output is 0. The run counter saturates, so a long burst stays muted.
- R8: A clean sample ends the run and is output unchanged. The next errored sample counts as error 1 again.
- R9: With cfg_en = 0, no concealment takes place in any mode.
- R10: stat_open goes to 1 on the clock that ends the 193rd consecutive frame without a parity error (in_chan = NUM_CH-1 ends a frame). Any errored sample clears stat_open on the next clock.
- R11: out_vbit, out_ubit, out_cbit and out_nonpcm load their inputs only on a clean valid sample while stat_open is 1. Otherwise they hold their value.
- R12: The last-clean store resets to 0, so a concealed sample before any clean sample on that channel outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_chan | input | CHW | Channel index of the sample |
| in_sample | input | SAMPLE_W | Sample data |
| in_perr | input | 1 | Parity error on this sample |
| in_nonpcm | input | 1 | Stream is flagged as non-PCM |
| in_vbit | input | 1 | Validity bit of the sample |
| in_ubit | input | 1 | User bit of the sample |
| in_cbit | input | 1 | Channel status bit of the sample |
| cfg_mode | input | 2 | 00 off, 01 PCM only, 10 PCM and non-PCM, 11 reserved |
| cfg_en | input | 1 | Parity processing enable |
| out_valid | output | 1 | Processed sample present |
| out_chan | output | CHW | Channel index of the processed sample |
| out_sample | output | SAMPLE_W | Processed sample |
| stat_open | output | 1 | Status refresh allowed |
| out_vbit | output | 1 | Held validity bit |
| out_ubit | output | 1 | Held user bit |
| out_cbit | output | 1 | Held channel status bit |
| out_nonpcm | output | 1 | Held non-PCM format flag |

## Verification
The assertions take for granted that in_chan always names an existing channel. They also assume that each sample is presented for exactly one clock with in_valid high. The configuration inputs are assumed to change only between samples. The stimulus drives every input on the falling edge, pulses in_valid for a single cycle per sample, uses only channel indices 0 and 1, and changes cfg_mode and cfg_en only while in_valid is low.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
   localparam logic [1:0] MODE_OFF = 2'b00;
   localparam logic [1:0] MODE_PCM = 2'b01;
   localparam logic [1:0] MODE_ALL = 2'b10;

   typedef enum logic [1:0] {
      ACT_PASS = 2'd0,
      ACT_HOLD = 2'd1,
      ACT_MUTE = 2'd2
   } act_e;

   function automatic logic conceal_applies(input logic [1:0] mode,
                                            input logic       en,
                                            input logic       nonpcm);
      logic r;
      r = 1'b0;
      if (en) begin
         case (mode)
            MODE_PCM: r = !nonpcm;
            MODE_ALL: r = 1'b1;
            default:  r = 1'b0;
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/pcu_err_track.sv
`timescale 1ns/1ps
module pcu_err_track #(
   parameter int HOLD_LIMIT = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   input  logic           smp_err,
   input  logic           active,
   output pcu_pkg::act_e  act
);
   localparam int CW = $clog2(HOLD_LIMIT + 2);
   localparam logic [CW-1:0] SAT = CW'(HOLD_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(HOLD_LIMIT);

   logic [CW-1:0] run_q;
   logic [CW-1:0] run_inc;
   logic          hit;

   assign hit = active && smp_err;

   always_comb begin
      run_inc = (run_q == SAT) ? SAT : run_q + 1'b1;
      act     = pcu_pkg::ACT_PASS;
      if (hit) act = (run_inc > LIM) ? pcu_pkg::ACT_MUTE : pcu_pkg::ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         run_q <= '0;
      else if (smp_valid) run_q <= hit ? run_inc : '0;
   end
endmodule

// File: rtl/pcu_hold_bank.sv
`timescale 1ns/1ps
module pcu_hold_bank #(
   parameter int W   = 24,
   parameter int NCH = 2,
   parameter int CHW = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [CHW-1:0] wr_chan,
   input  logic [W-1:0]   wr_data,
   input  logic [CHW-1:0] rd_chan,
   output logic [W-1:0]   rd_data
);
   logic [W-1:0] slot [NCH];

   for (genvar g = 0; g < NCH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) slot[g] <= '0;
         else if (wr_en && (wr_chan == CHW'(g))) slot[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCH; i++)
         if (rd_chan == CHW'(i)) rd_data = slot[i];
   end
endmodule

// File: rtl/pcu_stat_gate.sv
`timescale 1ns/1ps
module pcu_stat_gate #(
   parameter int BLOCK_FRAMES = 192,
   parameter int NCH          = 2,
   parameter int CHW          = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_valid,
   input  logic           smp_err,
   input  logic [CHW-1:0] smp_chan,
   input  logic [3:0]     stat_in,
   output logic           gate_open,
   output logic [3:0]     stat_out
);
   localparam int FW = $clog2(BLOCK_FRAMES + 2);
   localparam logic [FW-1:0] THR = FW'(BLOCK_FRAMES + 1);

   logic [FW-1:0] clean_q;
   logic          frame_bad_q;
   logic          frame_end;

   assign frame_end = (smp_chan == CHW'(NCH - 1));
   assign gate_open = (clean_q == THR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clean_q     <= '0;
         frame_bad_q <= 1'b0;
      end else if (smp_valid) begin
         if (smp_err) begin
            clean_q     <= '0;
            frame_bad_q <= !frame_end;
         end else if (frame_end) begin
            if (!frame_bad_q && (clean_q != THR)) clean_q <= clean_q + 1'b1;
            frame_bad_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_out <= '0;
      else if (smp_valid && !smp_err && gate_open) stat_out <= stat_in;
   end
endmodule

// File: rtl/parity_conceal.sv
`timescale 1ns/1ps
module parity_conceal #(
   parameter int SAMPLE_W     = 24,
   parameter int NUM_CH       = 2,
   parameter int HOLD_LIMIT   = 8,
   parameter int BLOCK_FRAMES = 192,
   parameter int CHW          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [CHW-1:0]      in_chan,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                in_perr,
   input  logic                in_nonpcm,
   input  logic                in_vbit,
   input  logic                in_ubit,
   input  logic                in_cbit,
   input  logic [1:0]          cfg_mode,
   input  logic                cfg_en,
   output logic                out_valid,
   output logic [CHW-1:0]      out_chan,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                stat_open,
   output logic                out_vbit,
   output logic                out_ubit,
   output logic                out_cbit,
   output logic                out_nonpcm
);
   initial begin
      if (SAMPLE_W < 1)     $fatal(1, "SAMPLE_W must be at least 1");
      if (NUM_CH < 1)       $fatal(1, "NUM_CH must be at least 1");
      if (HOLD_LIMIT < 1)   $fatal(1, "HOLD_LIMIT must be at least 1");
      if (BLOCK_FRAMES < 1) $fatal(1, "BLOCK_FRAMES must be at least 1");
   end

   logic                active;
   pcu_pkg::act_e       act;
   logic [SAMPLE_W-1:0] last_good;
   logic [3:0]          stat_held;

   assign active = in_valid && pcu_pkg::conceal_applies(cfg_mode, cfg_en, in_nonpcm);

   pcu_err_track #(.HOLD_LIMIT(HOLD_LIMIT)) u_track (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .smp_err(in_perr),
      .active(active), .act(act)
   );

   pcu_hold_bank #(.W(SAMPLE_W), .NCH(NUM_CH), .CHW(CHW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid && !in_perr), .wr_chan(in_chan),
      .wr_data(in_sample), .rd_chan(in_chan), .rd_data(last_good)
   );

   pcu_stat_gate #(.BLOCK_FRAMES(BLOCK_FRAMES), .NCH(NUM_CH), .CHW(CHW)) u_gate (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .smp_err(in_perr),
      .smp_chan(in_chan), .stat_in({in_nonpcm, in_cbit, in_ubit, in_vbit}),
      .gate_open(stat_open), .stat_out(stat_held)
   );

   assign {out_nonpcm, out_cbit, out_ubit, out_vbit} = stat_held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_chan   <= '0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_chan <= in_chan;
            case (act)
               pcu_pkg::ACT_HOLD: out_sample <= last_good;
               pcu_pkg::ACT_MUTE: out_sample <= '0;
               default:           out_sample <= in_sample;
            endcase
         end
      end
   end
endmodule

// File: rtl/parity_conceal_chk.sv
`timescale 1ns/1ps
module parity_conceal_chk #(
   parameter int SAMPLE_W   = 24,
   parameter int HOLD_LIMIT = 8,
   parameter int CHW        = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] in_sample,
   input logic                in_perr,
   input logic                in_nonpcm,
   input logic                in_vbit,
   input logic                in_ubit,
   input logic                in_cbit,
   input logic [1:0]          cfg_mode,
   input logic                cfg_en,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_sample,
   input logic                stat_open,
   input logic                out_vbit,
   input logic                out_ubit,
   input logic                out_cbit,
   input logic                out_nonpcm
);
   localparam int RW = $clog2(HOLD_LIMIT + 2);
   logic [RW-1:0] run;
   logic          applies;

   assign applies = cfg_en && ((cfg_mode == 2'b10) || (cfg_mode == 2'b01 && !in_nonpcm));

   always_ff @(posedge clk) begin
      if (!rst_n) run <= '0;
      else if (in_valid) begin
         if (applies && in_perr) run <= (run == RW'(HOLD_LIMIT + 1)) ? run : run + 1'b1;
         else run <= '0;
      end
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_sample == '0 && !stat_open));
   a_r2_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_mode == 2'b00) |=> (out_sample == $past(in_sample)));
   a_r3_reserved_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_mode == 2'b11) |=> (out_sample == $past(in_sample)));
   a_r7_mute_after_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && applies && in_perr && run >= RW'(HOLD_LIMIT)) |=> (out_sample == '0));
   a_r8_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_perr) |=> (out_sample == $past(in_sample)));
   a_r9_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_en) |=> (out_sample == $past(in_sample)));
   a_r10_error_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_perr) |=> !stat_open);
   a_r11_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && !in_perr && stat_open) |=> $stable({out_vbit, out_ubit, out_cbit, out_nonpcm}));
endmodule

bind parity_conceal parity_conceal_chk #(
   .SAMPLE_W(SAMPLE_W), .HOLD_LIMIT(HOLD_LIMIT), .CHW(CHW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
   .in_perr(in_perr), .in_nonpcm(in_nonpcm), .in_vbit(in_vbit), .in_ubit(in_ubit),
   .in_cbit(in_cbit), .cfg_mode(cfg_mode), .cfg_en(cfg_en), .out_valid(out_valid),
   .out_sample(out_sample), .stat_open(stat_open), .out_vbit(out_vbit),
   .out_ubit(out_ubit), .out_cbit(out_cbit), .out_nonpcm(out_nonpcm)
);

// File: tb/parity_conceal_tb.sv
`timescale 1ns/1ps
module parity_conceal_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [0:0]  in_chan = '0;
   logic [23:0] in_sample = '0;
   logic        in_perr = 1'b0, in_nonpcm = 1'b0;
   logic        in_vbit = 1'b0, in_ubit = 1'b0, in_cbit = 1'b0;
   logic [1:0]  cfg_mode = 2'b01;
   logic        cfg_en = 1'b1;
   logic        out_valid;
   logic [0:0]  out_chan;
   logic [23:0] out_sample;
   logic        stat_open, out_vbit, out_ubit, out_cbit, out_nonpcm;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   parity_conceal u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_sample(in_sample), .in_perr(in_perr), .in_nonpcm(in_nonpcm),
      .in_vbit(in_vbit), .in_ubit(in_ubit), .in_cbit(in_cbit),
      .cfg_mode(cfg_mode), .cfg_en(cfg_en), .out_valid(out_valid),
      .out_chan(out_chan), .out_sample(out_sample), .stat_open(stat_open),
      .out_vbit(out_vbit), .out_ubit(out_ubit), .out_cbit(out_cbit),
      .out_nonpcm(out_nonpcm)
   );

   task automatic expect_eq(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic put(input logic ch, input logic [23:0] d, input logic perr,
                      input logic npcm = 1'b0, input logic [2:0] vuc = 3'b000);
      @(negedge clk);
      in_valid = 1'b1; in_chan = ch; in_sample = d; in_perr = perr; in_nonpcm = npcm;
      {in_cbit, in_ubit, in_vbit} = vuc;
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] m, input logic e);
      @(negedge clk); cfg_mode = m; cfg_en = e;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      expect_eq("R1 out_valid", {31'd0, out_valid}, 0);
      expect_eq("R1 out_sample", {8'd0, out_sample}, 0);
      expect_eq("R1 stat_open", {31'd0, stat_open}, 0);
      expect_eq("R1 status", {28'd0, out_vbit, out_ubit, out_cbit, out_nonpcm}, 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_hold_mute;
      set_cfg(2'b10, 1'b1);
      put(0, 24'h5A5A5A, 1); expect_eq("R12 empty store", {8'd0, out_sample}, 0);
      put(0, 24'h000111, 0); expect_eq("R8 clean L", {8'd0, out_sample}, 32'h111);
      put(1, 24'h000222, 0); expect_eq("R8 clean R", {8'd0, out_sample}, 32'h222);
      for (int i = 0; i < 8; i++) begin
         put(i[0], 24'hBAD000 + 24'(i), 1);
         expect_eq("R6 hold per channel", {8'd0, out_sample}, i[0] ? 32'h222 : 32'h111);
      end
      put(0, 24'hBAD009, 1); expect_eq("R7 ninth mutes", {8'd0, out_sample}, 0);
      for (int i = 0; i < 30; i++) put(i[0], 24'hBAD100, 1);
      expect_eq("R7 long burst muted", {8'd0, out_sample}, 0);
      put(0, 24'h000333, 0); expect_eq("R8 resume", {8'd0, out_sample}, 32'h333);
      put(1, 24'hBAD200, 1); expect_eq("R8 run restarts", {8'd0, out_sample}, 32'h222);
      expect_eq("R6 out_chan", {31'd0, out_chan}, 1);
   endtask

   task automatic t_modes;
      set_cfg(2'b01, 1'b1);
      put(0, 24'h00000A, 0);
      put(0, 24'h00000B, 1, 1); expect_eq("R4 nonpcm passes", {8'd0, out_sample}, 32'hB);
      put(0, 24'h00000C, 1, 0); expect_eq("R4 pcm held", {8'd0, out_sample}, 32'hA);
      set_cfg(2'b10, 1'b1);
      put(0, 24'h00000D, 1, 1); expect_eq("R5 nonpcm held", {8'd0, out_sample}, 32'hA);
      set_cfg(2'b00, 1'b1);
      put(0, 24'h000077, 1); expect_eq("R2 off passes", {8'd0, out_sample}, 32'h77);
      set_cfg(2'b11, 1'b1);
      put(1, 24'h000088, 1); expect_eq("R3 reserved passes", {8'd0, out_sample}, 32'h88);
      set_cfg(2'b10, 1'b0);
      put(1, 24'h00000F, 1); expect_eq("R9 disabled passes", {8'd0, out_sample}, 32'hF);
      set_cfg(2'b10, 1'b1);
   endtask

   task automatic t_status;
      put(1, 24'h0, 1);
      for (int f = 0; f < 192; f++) begin
         put(0, 24'h10, 0, 0, 3'b111);
         put(1, 24'h20, 0, 0, 3'b111);
      end
      expect_eq("R10 closed at 192", {31'd0, stat_open}, 0);
      put(0, 24'h10, 0, 0, 3'b111);
      expect_eq("R10 closed mid frame", {31'd0, stat_open}, 0);
      put(1, 24'h20, 0, 0, 3'b111);
      expect_eq("R10 open at 193", {31'd0, stat_open}, 1);
      expect_eq("R11 no load while closed", {28'd0, out_vbit, out_ubit, out_cbit, out_nonpcm}, 0);
      put(0, 24'h10, 0, 1, 3'b101);
      expect_eq("R11 load when open", {28'd0, out_vbit, out_ubit, out_cbit, out_nonpcm}, 32'b1011);
      put(1, 24'h20, 1, 0, 3'b010);
      expect_eq("R10 error closes", {31'd0, stat_open}, 0);
      expect_eq("R11 hold on error", {28'd0, out_vbit, out_ubit, out_cbit, out_nonpcm}, 32'b1011);
      put(0, 24'h10, 0, 0, 3'b010);
      expect_eq("R11 hold after close", {28'd0, out_vbit, out_ubit, out_cbit, out_nonpcm}, 32'b1011);
   endtask

   initial begin
      t_reset;
      t_hold_mute;
      t_modes;
      t_status;
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule